// File: doc/BRIEF.md
# Nested Priority Level Sequencer

This block sits beside a mask-based interrupt controller and turns its flat per-source mask into nested priority levels. It holds three pieces of state. The first is a current level. The second is a word with one enable bit per source. The third is a table that lists, for each level, which sources that level may admit. The mask handed to the controller is always the table row for the current level ANDed with the enable word. Level 0 is the most urgent setting and admits nothing. Level N, where N is the number of sources, admits every enabled source.

Software or a sequencer drives it through single-cycle command strobes, each with one argument. A check scans the pending word for the lowest-numbered valid source and returns a vector together with the level in force before the check. It also moves the level to that source's number, so that only more urgent sources can interrupt it. An acknowledge puts back the level that the check returned. Set-level, enable and disable adjust the state directly. The table is filled through its own write port before the block is used. After reset the level is 0, and the start-up sequence then issues a set-level to N.

Top module: `prio_level_mgr`

## Requirements
- R1: Table row 0 is fixed at zero and table writes to index 0 are ignored, so the mask is zero whenever the level is 0.
- R2: maskOut equals table[level] AND the enable word, and reflects any state change from the previous clock edge.
- R3: A set-level with an argument in 0..N loads that level. A larger argument leaves the level unchanged. Either way, rspPrevLevel returns the level that was in force before the command.
- R4: Enable or disable with an argument in 0..N-1 sets or clears that source's enable bit. A larger argument raises rspErr and changes neither the enables nor the mask.
- R5: A check whose pending word, ANDed with VALID_MASK and restricted to bits at or above FIRST_BIT, is zero raises rspNone and leaves the level unchanged.
- R6: A check selects the lowest set bit at or above FIRST_BIT among the valid pending bits. Bits below FIRST_BIT and bits outside VALID_MASK are never selected.
- R7: A successful check returns rspVector = source + VEC_BASE and rspPrevLevel = the prior level, and loads the source number as the new level.
- R8: An acknowledge loads its argument as the level under the same range rule as set-level, and reports the prior level.
- R9: After reset the level is 0, all enables are 0, maskOut is 0 and all response flags are 0.
- R10: A table write takes effect on the mask after the same clock edge, including when it lands in the same cycle as a command that changes the level.
- R11: At most one command strobe is asserted per cycle. rspValid is high exactly in the cycle after a command, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdCheck | input | 1 | Scan pending word and raise level |
| cmdAck | input | 1 | Restore level given in cmdArg |
| cmdEnable | input | 1 | Set enable bit cmdArg |
| cmdDisable | input | 1 | Clear enable bit cmdArg |
| cmdSetLevel | input | 1 | Load level cmdArg |
| cmdArg | input | ARG_W | Level or source number for the command |
| tblWrEn | input | 1 | Table write strobe |
| tblIdx | input | LW | Table row to write |
| tblData | input | NUM_SRC | Allowed-source mask for that row |
| pendIn | input | NUM_SRC | Pending sources from the controller |
| maskOut | output | NUM_SRC | Mask driven to the controller |
| levelOut | output | LW | Current level |
| rspValid | output | 1 | Response pulse, one cycle after a command |
| rspNone | output | 1 | Check found nothing pending |
| rspErr | output | 1 | Enable or disable argument out of range |
| rspPrevLevel | output | LW | Level before the last command |
| rspVector | output | VW | Vector of the last successful check |

## Verification
The table write port is independent of the command strobes. A row can therefore be rewritten in the same cycle that a check moves the level onto that row. The bench does this on purpose: it writes a new row 3 while a check selects source 3. It then expects the mask after that edge to be the new row ANDed with the enables, not the old row. A mask built from the stale row, or a level update that is delayed relative to the table, shows up as a wrong maskOut.

// File: rtl/plm_pkg.sv
package plm_pkg;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic lvlLoad;    // load a new level
    logic lvlFromHit; // new level comes from the encoder, not cmdArg
    logic enSet;      // set enable bit cmdArg
    logic enClr;      // clear enable bit cmdArg
    logic vecLoad;    // capture a new vector
    logic rspLoad;    // a command was taken this cycle
    logic rspNone;    // check found nothing
    logic rspErr;     // enable/disable argument out of range
  } plm_strb_t;

endpackage

// File: rtl/plm_prio_enc.sv
module plm_prio_enc #(
  parameter int NUM_SRC = 8,
  parameter int FIRST_BIT = 0,
  parameter logic [NUM_SRC-1:0] VALID_MASK = '1,
  localparam int LW = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] pendIn,
  output logic               hit,
  output logic [LW-1:0]      hitIdx
);

  logic [NUM_SRC-1:0] scanWord;

  assign scanWord = pendIn & VALID_MASK;

  // Walk downward so the last match written is the lowest set bit
  always_comb begin
    hit = 1'b0;
    hitIdx = '0;
    for (int i = NUM_SRC - 1; i >= FIRST_BIT; i--) begin
      if (scanWord[i]) begin
        hit = 1'b1;
        hitIdx = LW'(i);
      end
    end
  end

endmodule

// File: rtl/plm_ctrl.sv
module plm_ctrl
  import plm_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ARG_W = 8
) (
  input  logic             cmdCheck,
  input  logic             cmdAck,
  input  logic             cmdEnable,
  input  logic             cmdDisable,
  input  logic             cmdSetLevel,
  input  logic [ARG_W-1:0] cmdArg,
  input  logic             hit,
  output plm_strb_t        strb
);

  logic argIsLevel;
  logic argIsSrc;

  assign argIsLevel = cmdArg <= ARG_W'(NUM_SRC);
  assign argIsSrc   = cmdArg <  ARG_W'(NUM_SRC);

  always_comb begin
    strb = '0;
    strb.rspLoad = cmdCheck | cmdAck | cmdEnable | cmdDisable | cmdSetLevel;
    if (cmdCheck) begin
      if (hit) begin
        strb.lvlLoad = 1'b1;
        strb.lvlFromHit = 1'b1;
        strb.vecLoad = 1'b1;
      end else begin
        strb.rspNone = 1'b1;
      end
    end else if (cmdAck || cmdSetLevel) begin
      strb.lvlLoad = argIsLevel;
    end else if (cmdEnable) begin
      strb.enSet = argIsSrc;
      strb.rspErr = !argIsSrc;
    end else if (cmdDisable) begin
      strb.enClr = argIsSrc;
      strb.rspErr = !argIsSrc;
    end
  end

endmodule

// File: rtl/plm_dpath.sv
module plm_dpath
  import plm_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ARG_W = 8,
  parameter int VW = 8,
  parameter int VEC_BASE = 0,
  localparam int LW = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  plm_strb_t          strb,
  input  logic [ARG_W-1:0]   cmdArg,
  input  logic [LW-1:0]      hitIdx,
  input  logic               tblWrEn,
  input  logic [LW-1:0]      tblIdx,
  input  logic [NUM_SRC-1:0] tblData,
  output logic [NUM_SRC-1:0] maskOut,
  output logic [LW-1:0]      levelOut,
  output logic               rspValid,
  output logic               rspNone,
  output logic               rspErr,
  output logic [LW-1:0]      rspPrevLevel,
  output logic [VW-1:0]      rspVector
);

  logic [NUM_SRC:0][NUM_SRC-1:0] tblQ;
  logic [LW-1:0]      levelQ;
  logic [LW-1:0]      levelNext;
  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] enBit;
  logic [LW-1:0]      argLvl;

  assign argLvl = cmdArg[LW-1:0];

  // Level table: row 0 is tied to zero, the others are written one at a time
  for (genvar g = 0; g <= NUM_SRC; g++) begin : gRow
    if (g == 0) begin : gZero
      assign tblQ[g] = '0;
    end else begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) tblQ[g] <= '0;
        else if (tblWrEn && tblIdx == LW'(g)) tblQ[g] <= tblData;
      end
    end
  end

  // One-hot decode of the source argument
  always_comb begin
    enBit = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (argLvl == LW'(i)) enBit[i] = 1'b1;
    end
  end

  assign levelNext = strb.lvlFromHit ? hitIdx : argLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
    end else if (strb.lvlLoad) begin
      levelQ <= levelNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= '0;
    end else if (strb.enSet) begin
      enQ <= enQ | enBit;
    end else if (strb.enClr) begin
      enQ <= enQ & ~enBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspNone <= 1'b0;
      rspErr <= 1'b0;
      rspPrevLevel <= '0;
    end else begin
      rspValid <= strb.rspLoad;
      rspNone <= strb.rspNone;
      rspErr <= strb.rspErr;
      if (strb.rspLoad) rspPrevLevel <= levelQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspVector <= '0;
    end else if (strb.vecLoad) begin
      rspVector <= VW'(hitIdx) + VW'(VEC_BASE);
    end
  end

  assign maskOut = tblQ[levelQ] & enQ;
  assign levelOut = levelQ;

endmodule

// File: rtl/prio_level_mgr.sv
module prio_level_mgr
  import plm_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int FIRST_BIT = 0,
  parameter logic [NUM_SRC-1:0] VALID_MASK = '1,
  parameter int VEC_BASE = 0,
  parameter int VW = 8,
  parameter int ARG_W = 8,
  localparam int LW = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdCheck,
  input  logic               cmdAck,
  input  logic               cmdEnable,
  input  logic               cmdDisable,
  input  logic               cmdSetLevel,
  input  logic [ARG_W-1:0]   cmdArg,
  input  logic               tblWrEn,
  input  logic [LW-1:0]      tblIdx,
  input  logic [NUM_SRC-1:0] tblData,
  input  logic [NUM_SRC-1:0] pendIn,
  output logic [NUM_SRC-1:0] maskOut,
  output logic [LW-1:0]      levelOut,
  output logic               rspValid,
  output logic               rspNone,
  output logic               rspErr,
  output logic [LW-1:0]      rspPrevLevel,
  output logic [VW-1:0]      rspVector
);

  plm_strb_t     strb;
  logic          hit;
  logic [LW-1:0] hitIdx;

  plm_prio_enc #(
    .NUM_SRC(NUM_SRC), .FIRST_BIT(FIRST_BIT), .VALID_MASK(VALID_MASK)
  ) uEnc (
    .pendIn(pendIn), .hit(hit), .hitIdx(hitIdx)
  );

  plm_ctrl #(.NUM_SRC(NUM_SRC), .ARG_W(ARG_W)) uCtrl (
    .cmdCheck(cmdCheck), .cmdAck(cmdAck), .cmdEnable(cmdEnable),
    .cmdDisable(cmdDisable), .cmdSetLevel(cmdSetLevel),
    .cmdArg(cmdArg), .hit(hit), .strb(strb)
  );

  plm_dpath #(
    .NUM_SRC(NUM_SRC), .ARG_W(ARG_W), .VW(VW), .VEC_BASE(VEC_BASE)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdArg(cmdArg), .hitIdx(hitIdx),
    .tblWrEn(tblWrEn), .tblIdx(tblIdx), .tblData(tblData),
    .maskOut(maskOut), .levelOut(levelOut), .rspValid(rspValid),
    .rspNone(rspNone), .rspErr(rspErr), .rspPrevLevel(rspPrevLevel),
    .rspVector(rspVector)
  );

endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
  parameter int NUM_SRC = 8,
  parameter int FIRST_BIT = 0,
  parameter logic [NUM_SRC-1:0] VALID_MASK = '1,
  parameter int VEC_BASE = 0,
  parameter int VW = 8,
  parameter int ARG_W = 8,
  localparam int LW = $clog2(NUM_SRC + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdCheck,
  input logic               cmdAck,
  input logic               cmdEnable,
  input logic               cmdDisable,
  input logic               cmdSetLevel,
  input logic [ARG_W-1:0]   cmdArg,
  input logic               tblWrEn,
  input logic [NUM_SRC-1:0] pendIn,
  input logic [NUM_SRC-1:0] maskOut,
  input logic [LW-1:0]      levelOut,
  input logic               rspValid,
  input logic               rspNone,
  input logic               rspErr,
  input logic [LW-1:0]      rspPrevLevel,
  input logic [VW-1:0]      rspVector
);

  logic anyCmd;
  logic nonePend;
  logic badLevel;
  logic badSrc;

  assign anyCmd   = cmdCheck | cmdAck | cmdEnable | cmdDisable | cmdSetLevel;
  assign nonePend = ((pendIn & VALID_MASK) >> FIRST_BIT) == '0;
  assign badLevel = cmdArg > ARG_W'(NUM_SRC);
  assign badSrc   = cmdArg >= ARG_W'(NUM_SRC);

  AST_LEVEL0_MASK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    levelOut == '0 |-> maskOut == '0); // R1

  AST_SET_PREV_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    cmdSetLevel |=> rspValid && rspPrevLevel == $past(levelOut)); // R3

  AST_BAD_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSetLevel || cmdAck) && badLevel |=> levelOut == $past(levelOut)); // R3

  AST_BAD_SRC_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnable || cmdDisable) && badSrc && !tblWrEn |=> rspErr && $stable(maskOut)); // R4

  AST_NONE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    cmdCheck && nonePend |=> rspNone && levelOut == $past(levelOut)); // R5

  AST_CHECK_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    cmdCheck && !nonePend |=> !rspNone && rspVector == VW'(levelOut) + VW'(VEC_BASE)); // R7

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdCheck, cmdAck, cmdEnable, cmdDisable, cmdSetLevel})); // R11

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !anyCmd |=> !rspValid); // R11

endmodule

bind prio_level_mgr plm_checker #(
  .NUM_SRC(NUM_SRC), .FIRST_BIT(FIRST_BIT), .VALID_MASK(VALID_MASK),
  .VEC_BASE(VEC_BASE), .VW(VW), .ARG_W(ARG_W)
) uChk (
  .clk(clk), .rstN(rstN), .cmdCheck(cmdCheck), .cmdAck(cmdAck),
  .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdSetLevel(cmdSetLevel),
  .cmdArg(cmdArg), .tblWrEn(tblWrEn), .pendIn(pendIn), .maskOut(maskOut),
  .levelOut(levelOut), .rspValid(rspValid), .rspNone(rspNone),
  .rspErr(rspErr), .rspPrevLevel(rspPrevLevel), .rspVector(rspVector)
);

// File: tb/tb_prio_level_mgr.sv
`timescale 1ns/100ps
module tb_prio_level_mgr;

  localparam int NSRC = 8;
  localparam int LWB = 4;
  localparam int VBASE = 16;

  localparam logic [2:0] OP_CHK = 3'd1;
  localparam logic [2:0] OP_ACK = 3'd2;
  localparam logic [2:0] OP_EN  = 3'd3;
  localparam logic [2:0] OP_DIS = 3'd4;
  localparam logic [2:0] OP_SET = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] arg;
    logic [7:0] pend;
    logic [3:0] lvl;
    logic [7:0] mask;
    logic [3:0] prev;
    logic       none;
    logic       err;
    logic [7:0] vec;
  } vec_t;

  // FIRST_BIT = 1, VALID_MASK = 0x7F, row k = (1<<k)-1, row 8 = 0xFF
  localparam vec_t VECS [18] = '{
    '{OP_SET, 8'd8,  8'h00, 4'd8, 8'h00, 4'd0, 1'b0, 1'b0, 8'd0},
    '{OP_EN,  8'd2,  8'h00, 4'd8, 8'h04, 4'd8, 1'b0, 1'b0, 8'd0},
    '{OP_EN,  8'd5,  8'h00, 4'd8, 8'h24, 4'd8, 1'b0, 1'b0, 8'd0},
    '{OP_EN,  8'd0,  8'h00, 4'd8, 8'h25, 4'd8, 1'b0, 1'b0, 8'd0},
    '{OP_EN,  8'd9,  8'h00, 4'd8, 8'h25, 4'd8, 1'b0, 1'b1, 8'd0},
    '{OP_CHK, 8'd0,  8'h24, 4'd2, 8'h01, 4'd8, 1'b0, 1'b0, 8'd18},
    '{OP_CHK, 8'd0,  8'h01, 4'd2, 8'h01, 4'd2, 1'b1, 1'b0, 8'd0},
    '{OP_CHK, 8'd0,  8'h81, 4'd2, 8'h01, 4'd2, 1'b1, 1'b0, 8'd0},
    '{OP_CHK, 8'd0,  8'h60, 4'd5, 8'h05, 4'd2, 1'b0, 1'b0, 8'd21},
    '{OP_ACK, 8'd2,  8'h00, 4'd2, 8'h01, 4'd5, 1'b0, 1'b0, 8'd0},
    '{OP_ACK, 8'd8,  8'h00, 4'd8, 8'h25, 4'd2, 1'b0, 1'b0, 8'd0},
    '{OP_SET, 8'd12, 8'h00, 4'd8, 8'h25, 4'd8, 1'b0, 1'b0, 8'd0},
    '{OP_DIS, 8'd5,  8'h00, 4'd8, 8'h05, 4'd8, 1'b0, 1'b0, 8'd0},
    '{OP_DIS, 8'd0,  8'h00, 4'd8, 8'h04, 4'd8, 1'b0, 1'b0, 8'd0},
    '{OP_SET, 8'd0,  8'h00, 4'd0, 8'h00, 4'd8, 1'b0, 1'b0, 8'd0},
    '{OP_SET, 8'd3,  8'h00, 4'd3, 8'h04, 4'd0, 1'b0, 1'b0, 8'd0},
    '{OP_CHK, 8'd0,  8'h06, 4'd1, 8'h00, 4'd3, 1'b0, 1'b0, 8'd17},
    '{OP_DIS, 8'd8,  8'h00, 4'd1, 8'h00, 4'd1, 1'b0, 1'b1, 8'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdCheck = 0, cmdAck = 0, cmdEnable = 0, cmdDisable = 0, cmdSetLevel = 0;
  logic [7:0] cmdArg = '0;
  logic tblWrEn = 0;
  logic [LWB-1:0] tblIdx = '0;
  logic [NSRC-1:0] tblData = '0;
  logic [NSRC-1:0] pendIn = '0;
  logic [NSRC-1:0] maskOut;
  logic [LWB-1:0] levelOut;
  logic rspValid, rspNone, rspErr;
  logic [LWB-1:0] rspPrevLevel;
  logic [7:0] rspVector;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prio_level_mgr #(
    .NUM_SRC(NSRC), .FIRST_BIT(1), .VALID_MASK(8'h7F),
    .VEC_BASE(VBASE), .VW(8), .ARG_W(8)
  ) dut (
    .clk(clk), .rstN(rstN), .cmdCheck(cmdCheck), .cmdAck(cmdAck),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdSetLevel(cmdSetLevel),
    .cmdArg(cmdArg), .tblWrEn(tblWrEn), .tblIdx(tblIdx), .tblData(tblData),
    .pendIn(pendIn), .maskOut(maskOut), .levelOut(levelOut),
    .rspValid(rspValid), .rspNone(rspNone), .rspErr(rspErr),
    .rspPrevLevel(rspPrevLevel), .rspVector(rspVector)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setOp(input logic [2:0] op);
    cmdCheck = (op == OP_CHK);
    cmdAck = (op == OP_ACK);
    cmdEnable = (op == OP_EN);
    cmdDisable = (op == OP_DIS);
    cmdSetLevel = (op == OP_SET);
  endtask

  // Drive at a falling edge, hold over one rising edge, return at the next falling edge
  task automatic runCmd(input logic [2:0] op, input logic [7:0] arg, input logic [7:0] pend);
    @(negedge clk);
    setOp(op);
    cmdArg = arg;
    pendIn = pend;
    @(negedge clk);
    setOp(3'd0);
    tblWrEn = 1'b0;
  endtask

  task automatic writeRow(input int idx, input logic [7:0] data);
    @(negedge clk);
    tblWrEn = 1'b1;
    tblIdx = LWB'(idx);
    tblData = data;
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      OP_CHK: return "R6 R7";
      OP_ACK: return "R8";
      OP_SET: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9: state straight out of reset
    check("R9", "level", levelOut, 0);
    check("R9", "mask", maskOut, 0);
    check("R9", "valid", rspValid, 0);
    check("R9", "err", rspErr, 0);
    rstN = 1'b1;
    @(negedge clk);

    writeRow(0, 8'hFF); // R1: must be ignored
    for (int k = 1; k <= NSRC; k++) writeRow(k, 8'((1 << k) - 1));

    for (int i = 0; i < 18; i++) begin
      runCmd(VECS[i].op, VECS[i].arg, VECS[i].pend);
      check(reqOf(VECS[i].op), "level", levelOut, VECS[i].lvl);
      check("R2", "mask", maskOut, VECS[i].mask);
      check("R11", "rspValid", rspValid, 1);
      check("R4", "rspErr", rspErr, VECS[i].err);
      check("R5", "rspNone", rspNone, VECS[i].none);
      if (VECS[i].op == OP_SET || VECS[i].op == OP_ACK ||
          (VECS[i].op == OP_CHK && !VECS[i].none))
        check(reqOf(VECS[i].op), "prevLevel", rspPrevLevel, VECS[i].prev);
      if (VECS[i].op == OP_CHK && !VECS[i].none)
        check("R7", "vector", rspVector, VECS[i].vec);
    end

    // R11: no command, no response pulse
    @(negedge clk);
    check("R11", "idle rspValid", rspValid, 0);

    // R1: level 0 with every source enabled still gives a zero mask
    for (int s = 0; s < NSRC; s++) runCmd(OP_EN, 8'(s), 8'h00);
    runCmd(OP_SET, 8'd0, 8'h00);
    check("R1", "mask at level 0", maskOut, 0);

    // R10: rewrite row 3 in the same cycle as a check that selects source 3
    runCmd(OP_SET, 8'd8, 8'h00);
    @(negedge clk);
    tblWrEn = 1'b1;
    tblIdx = 4'd3;
    tblData = 8'h0C;
    setOp(OP_CHK);
    pendIn = 8'h08;
    @(negedge clk);
    setOp(3'd0);
    tblWrEn = 1'b0;
    check("R10", "level", levelOut, 3);
    check("R10", "mask with new row", maskOut, 8'h0C);
    check("R7", "vector", rspVector, 3 + VBASE);

    // R4: out-of-range disable leaves the enables intact
    runCmd(OP_DIS, 8'd200, 8'h00);
    check("R4", "err", rspErr, 1);
    runCmd(OP_SET, 8'd8, 8'h00);
    check("R4", "enables intact", maskOut, 8'hFF);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule